// File: doc/BRIEF.md
# Delay-two inverse decoder for a four-state binary encoder

This block pairs a fixed four-state binary Mealy encoder with its minimized six-state inverse. The encoder turns one plain bit per cycle into one coded bit per cycle. The inverse machine reads the coded stream at the same rate. Two symbols later, it gives back the plain stream.

The encoder can start in any of its four states, and the start state is loaded during reset. The inverse machine has no copy of the encoder and no delay line. It holds only three state bits. Its reset state is picked from the encoder start state so that the two machines begin in step. The first two recovered bits come before the inverse has enough coded history, so a valid flag marks them as not valid.

Top module: `inv_pair_top`

## Requirements
- R1: Encoder states are coded A=0, B=1, C=2, D=3. On plain bit 0 / 1 the encoder moves and emits as follows: A goes to C with 0 / to D with 1; B goes to D with 0 / to C with 1; C goes to A with 0 / to B with 0; D goes to C with 1 / to D with 1. The coded bit is a combinational function of the current state and `plain_bit`.
- R2: While `rst` is high at a rising edge, the encoder loads the state on `enc_start`. The first symbol after reset is encoded from that state.
- R3: `rec_valid` is low while `rst` is high and for the first two symbols after reset. It is high from the third symbol onward, until the next reset.
- R4: When `rec_valid` is high, `rec_bit` equals the `plain_bit` applied two symbols earlier.
- R5: The inverse machine resets to one state when the encoder start is A or B, and to a second state when the start is C or D. With these reset states, R4 holds for all four encoder start states.
- R6: A reset in the middle of a stream restarts both machines. Validity drops again for two symbols, and recovery resumes with the new start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_start | input | 2 | Encoder start state loaded during reset (A=0..D=3) |
| plain_bit | input | 1 | Plain bit for the current symbol |
| coded_bit | output | 1 | Encoder output for the current symbol |
| rec_bit | output | 1 | Recovered plain bit from two symbols back |
| rec_valid | output | 1 | High when `rec_bit` is a recovered bit |

## Verification
The coded bit and the recovered bit are both combinational in the current symbol. The bench therefore drives each plain bit on the falling edge and samples both outputs a moment later, in the same half cycle. The expected recovered bit is read from a two-entry history of the bits the bench itself applied. The expected valid flag comes from a count of symbols since reset, so the third symbol after each reset is the first one compared. Every start state is covered by a reset followed by directed and random streams, and one reset falls in the middle of a stream.

// File: rtl/inv_pair_pkg.sv
package inv_pair_pkg;

    typedef enum logic [1:0] {
        ENC_A = 2'd0,
        ENC_B = 2'd1,
        ENC_C = 2'd2,
        ENC_D = 2'd3
    } enc_state_t;

    typedef enum logic [2:0] {
        INV_E = 3'd0,
        INV_F = 3'd1,
        INV_G = 3'd2,
        INV_H = 3'd3,
        INV_I = 3'd4,
        INV_J = 3'd5
    } inv_state_t;

    localparam int unsigned INV_STATES = 6;
    localparam int unsigned RECOVERY_LAT = 2;

endpackage

// File: rtl/inv_pair_enc.sv
module inv_pair_enc
    import inv_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] start_i,
    input  logic       x_i,
    output logic       z_o
);

    typedef struct packed {
        enc_state_t st;
    } enc_regs_t;

    enc_regs_t r_d, r_q;
    logic      z_c;

    always_comb begin
        r_d = r_q;
        z_c = 1'b0;
        unique case (r_q.st)
            ENC_A: begin r_d.st = x_i ? ENC_D : ENC_C; z_c = x_i;  end
            ENC_B: begin r_d.st = x_i ? ENC_C : ENC_D; z_c = x_i;  end
            ENC_C: begin r_d.st = x_i ? ENC_B : ENC_A; z_c = 1'b0; end
            ENC_D: begin r_d.st = x_i ? ENC_D : ENC_C; z_c = 1'b1; end
            default: begin r_d.st = ENC_A; z_c = 1'b0; end
        endcase
        if (rst) begin
            r_d.st = enc_state_t'(start_i);
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign z_o = z_c;

    // R2: the reset load takes the requested start state
    p_start_load_r2: assert property (@(posedge clk)
        rst |=> (r_q.st == enc_state_t'($past(start_i))));

    // R1: from D the encoder can only reach C or D
    p_d_succ_r1: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ENC_D) |=> (r_q.st == ENC_C || r_q.st == ENC_D));

endmodule

// File: rtl/inv_pair_dec.sv
module inv_pair_dec
    import inv_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] start_i,
    input  logic       z_i,
    output logic       x_o
);

    typedef struct packed {
        inv_state_t st;
    } dec_regs_t;

    dec_regs_t  r_d, r_q;
    logic       x_c;
    inv_state_t start_st;

    // Encoder start A/B pairs with E, C/D pairs with G
    assign start_st = start_i[1] ? INV_G : INV_E;

    always_comb begin
        r_d = r_q;
        x_c = 1'b0;
        case (r_q.st)
            INV_E: begin r_d.st = z_i ? INV_J : INV_I; x_c = 1'b0; end
            INV_F: begin r_d.st = z_i ? INV_F : INV_E; x_c = 1'b1; end
            INV_G: begin r_d.st = z_i ? INV_F : INV_E; x_c = 1'b0; end
            INV_H: begin r_d.st = z_i ? INV_J : INV_I; x_c = 1'b1; end
            INV_I: begin r_d.st = z_i ? INV_G : INV_E; x_c = z_i;  end
            INV_J: begin r_d.st = z_i ? INV_F : INV_H; x_c = ~z_i; end
            default: begin r_d.st = INV_E; x_c = 1'b0; end
        endcase
        if (rst) begin
            r_d.st = start_st;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign x_o = x_c;

    // R5: reset state follows the encoder start state
    p_reset_pick_r5: assert property (@(posedge clk)
        rst |=> (r_q.st == ($past(start_i[1]) ? INV_G : INV_E)));

    // R5: only the six defined inverse states are ever occupied
    p_legal_state_r5: assert property (@(posedge clk) disable iff (rst)
        (r_q.st < 3'(INV_STATES)));

endmodule

// File: rtl/inv_pair_valid.sv
module inv_pair_valid #(
    parameter int unsigned LAT = 2
) (
    input  logic clk,
    input  logic rst,
    output logic valid_o
);

    localparam int unsigned CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LAT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } val_regs_t;

    val_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt != CMAX) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        if (rst) begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign valid_o = (r_q.cnt == CMAX);

    // R3: the count never passes its limit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (r_q.cnt <= CMAX));

    // R3: once valid, it stays valid until reset
    p_valid_hold_r3: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o);

endmodule

// File: rtl/inv_pair_top.sv
module inv_pair_top
    import inv_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] enc_start,
    input  logic       plain_bit,
    output logic       coded_bit,
    output logic       rec_bit,
    output logic       rec_valid
);

    logic z_w;

    inv_pair_enc u_enc (
        .clk     (clk),
        .rst     (rst),
        .start_i (enc_start),
        .x_i     (plain_bit),
        .z_o     (z_w)
    );

    inv_pair_dec u_dec (
        .clk     (clk),
        .rst     (rst),
        .start_i (enc_start),
        .z_i     (z_w),
        .x_o     (rec_bit)
    );

    inv_pair_valid #(.LAT(RECOVERY_LAT)) u_val (
        .clk     (clk),
        .rst     (rst),
        .valid_o (rec_valid)
    );

    assign coded_bit = z_w;

    // R4: recovered bit is the plain bit of two symbols earlier
    p_delay_match_r4: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_bit == $past(plain_bit, 2)));

    // R3: validity is never claimed on the first symbol after reset
    p_no_early_valid_r3: assert property (@(posedge clk)
        rst |=> !rec_valid);

endmodule

// File: tb/tb_inv_pair_top.sv
`timescale 1ns/1ps
module tb_inv_pair_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] enc_start = 2'd0;
    logic       plain_bit = 1'b0;
    logic       coded_bit, rec_bit, rec_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [1:0] m_state;
    int         m_count;
    logic       h1, h2;

    inv_pair_top dut (
        .clk       (clk),
        .rst       (rst),
        .enc_start (enc_start),
        .plain_bit (plain_bit),
        .coded_bit (coded_bit),
        .rec_bit   (rec_bit),
        .rec_valid (rec_valid)
    );

    always #5 clk = ~clk;

    // Encoder model from R1: returns {next_state, coded}
    function automatic logic [2:0] enc_model(input logic [1:0] s, input logic x);
        case (s)
            2'd0: enc_model = x ? {2'd3, 1'b1} : {2'd2, 1'b0};
            2'd1: enc_model = x ? {2'd2, 1'b1} : {2'd3, 1'b0};
            2'd2: enc_model = x ? {2'd1, 1'b0} : {2'd0, 1'b0};
            default: enc_model = x ? {2'd3, 1'b1} : {2'd2, 1'b1};
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst = 1'b1;
        enc_start = s;
        @(posedge clk);
        #1;
        chk(rec_valid, 1'b0, "R3 valid low in reset");
        @(negedge clk);
        rst = 1'b0;
        enc_start = ~s;
        m_state = s;
        m_count = 0;
        h1 = 1'b0;
        h2 = 1'b0;
    endtask

    // Applies one symbol on the falling edge; the caller is already at it
    task automatic step(input logic x);
        logic [2:0] r;
        plain_bit = x;
        #1;
        r = enc_model(m_state, x);
        chk(coded_bit, r[0], "R1/R2 coded bit");
        chk(rec_valid, (m_count >= 2), "R3 valid timing");
        if (m_count >= 2) chk(rec_bit, h2, "R4/R5 recovered bit");
        m_state = r[2:1];
        h2 = h1;
        h1 = x;
        m_count++;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd24681));
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            for (int i = 0; i < 12; i++) step(1'b0);
            do_reset(2'(s));
            for (int i = 0; i < 12; i++) step(1'b1);
            do_reset(2'(s));
            for (int i = 0; i < 12; i++) step(1'(i & 1));
            do_reset(2'(s));
            for (int i = 0; i < 200; i++) step(1'($urandom_range(0, 1)));
        end
        // R6: reset in mid-stream, with a new start state each time
        do_reset(2'd0);
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < 7; i++) step(1'($urandom_range(0, 1)));
            do_reset(2'($urandom_range(0, 3)));
            step(1'b1);
            chk(rec_valid, 1'b0, "R6 valid dropped after mid-stream reset");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule